// File: doc/BRIEF.md
# Load Memory-Dependence Predictor

This block decides, for each load leaving the scheduler, whether the load may execute ahead of older stores whose addresses are still unknown. A history table holds one saturating confidence counter per entry. The table is indexed by XOR-folding the load's instruction pointer, and the block reports "go" only when that counter has reached its maximum. A small load buffer keeps the disambiguation status of every load in flight. Each entry records whether the table must be trained at commit, whether the load has executed, and whether a later-resolving older store hit it.

The surrounding pipeline supplies the load-buffer slot at dispatch, along with the load's age tag, its address and whether older stores have unknown addresses. It signals when a held load is released, and it broadcasts each store address as it resolves. It also names the slot of each load that commits. The block answers with an issue decision at dispatch and a one-cycle violation pulse that carries the offending slot. Flushing and replay after a violation are left to the pipeline. Only a commit trains the table: the counter is cleared if the load was hit and incremented otherwise.

Top module: `ld_dep_predictor`

## Requirements
- R1: The table index is the XOR of consecutive 6-bit chunks of the 32-bit instruction pointer (bits 5:0, 11:6, … , 31:30 zero-extended), so two pointers that fold to the same value share an entry.
- R2: After reset every counter is 0, and `disp_go` is 1 in the same cycle exactly when the counter at the index of `disp_ip` equals 15.
- R3: `disp_issue` is 1 exactly when `disp_valid` is 1 and either `disp_older_unk` is 0 or `disp_go` is 1. An issued load is marked as executed, and a held load is not.
- R4: A resolving store (`st_valid`) flags every valid load entry that meets four conditions: its address is valid, it has executed, it is younger than the store, and bits 31:3 of its address equal those of the store. Younger means that (load age − store age) mod 64 is nonzero and below 32. In the next cycle, and only then, `viol_valid` is 1 and `viol_slot` gives the lowest flagged slot.
- R5: A commit of an entry whose load saw older unknown stores at dispatch, and that was not flagged, increments its counter, which stays at 15 once there.
- R6: A commit of such an entry that was flagged clears its counter to 0.
- R7: A commit of an entry dispatched with `disp_older_unk` = 0 leaves the table unchanged.
- R8: When a commit and a lookup touch the same index in one cycle, the lookup reports the value from before the commit.
- R9: A release (`rel_valid`) marks a held load as executed, so that it becomes subject to R4.
- R10: A committed entry is freed and no longer takes part in store comparison.
- R11: Address bits 2:0 and loads dispatched with `disp_addr_vld` = 0 never cause a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | A load leaves the scheduler this cycle |
| disp_slot | input | 3 | Load-buffer slot given to the load |
| disp_ip | input | 32 | Instruction pointer of the load (lookup is also valid without disp_valid) |
| disp_age | input | 6 | Program-order age tag of the load |
| disp_addr | input | 32 | Load address |
| disp_addr_vld | input | 1 | Load address is known |
| disp_older_unk | input | 1 | Some older store still has an unknown address |
| disp_go | output | 1 | Counter for disp_ip is saturated |
| disp_issue | output | 1 | Load may execute now |
| rel_valid | input | 1 | A held load now executes |
| rel_slot | input | 3 | Slot of the released load |
| st_valid | input | 1 | A store address resolves |
| st_age | input | 6 | Age tag of that store |
| st_addr | input | 32 | Resolved store address |
| cm_valid | input | 1 | A load commits |
| cm_slot | input | 3 | Slot of the committing load |
| viol_valid | output | 1 | One-cycle violation pulse |
| viol_slot | output | 3 | Slot of the violating load |

## Verification
The predictor is first trained through repeated dispatch, release and commit rounds until the counter saturates. The bench then probes an aliasing pointer and a neighbouring one, which separates a correct fold from a plain low-bit index. Store broadcasts are tried against several loads in turn:
- a load that is older than the store
- a load in a different 8-byte line
- a load that differs only in bits 2:0
- a held load, then the same load after release
- a load without a valid address
- two loads hit at once

Together these separate the age, line, executed and priority conditions. Commits with and without the update condition, a commit that coincides with a lookup of the same index, and stores that arrive after commit separate training, read-before-write ordering and entry release.

// File: rtl/ldp_pkg.sv
package ldp_pkg;
  localparam int unsigned IP_W_DEF     = 32;
  localparam int unsigned ADDR_W_DEF   = 32;
  localparam int unsigned TBL_IDX_DEF  = 6;
  localparam int unsigned CTR_W_DEF    = 4;
  localparam int unsigned LB_N_DEF     = 8;
  localparam int unsigned AGE_W_DEF    = 6;
  localparam int unsigned LINE_LSB_DEF = 3;

  // status bits kept for every load-buffer entry
  typedef struct packed {
    logic vld;   // entry holds a load
    logic avld;  // load address known
    logic upd;   // train table at commit
    logic done;  // load has executed
    logic hit;   // an older store matched after execution
  } lb_flags_t;
endpackage

// File: rtl/ldp_hist_table.sv
module ldp_hist_table #(
  parameter int unsigned IP_W  = 32,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IP_W-1:0]  lk_ip,
  output logic [IDX_W-1:0] lk_idx,
  output logic             lk_go,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_clr
);
  localparam int unsigned DEPTH  = 1 << IDX_W;
  localparam int unsigned NCHUNK = (IP_W + IDX_W - 1) / IDX_W;
  localparam int unsigned PAD_W  = NCHUNK * IDX_W;
  localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};

  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [CTR_W-1:0] ctr_d [DEPTH];
  logic [PAD_W-1:0] ip_pad;

  // fold the pointer into the table index
  always_comb begin
    ip_pad = PAD_W'(lk_ip);
    lk_idx = '0;
    for (int c = 0; c < NCHUNK; c++) begin
      lk_idx = lk_idx ^ ip_pad[c*IDX_W +: IDX_W];
    end
  end

  assign lk_go = (ctr_q[lk_idx] == CMAX);

  always_comb begin
    ctr_d = ctr_q;
    if (wr_en) begin
      if (wr_clr) begin
        ctr_d[wr_idx] = '0;
      end else if (ctr_q[wr_idx] != CMAX) begin
        ctr_d[wr_idx] = ctr_q[wr_idx] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= '{default: '0};
    end else if (wr_en) begin
      ctr_q <= ctr_d;
    end
  end

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_clr && ctr_q[wr_idx] == CMAX) |=> ctr_q[$past(wr_idx)] == CMAX);
  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_clr) |=> ctr_q[$past(wr_idx)] == '0);
endmodule

// File: rtl/ldp_load_buf.sv
module ldp_load_buf
  import ldp_pkg::*;
#(
  parameter int unsigned LB_N     = 8,
  parameter int unsigned AGE_W    = 6,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned LINE_LSB = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    al_en,
  input  logic [$clog2(LB_N)-1:0] al_slot,
  input  logic [AGE_W-1:0]        al_age,
  input  logic [ADDR_W-1:0]       al_addr,
  input  logic                    al_avld,
  input  logic                    al_upd,
  input  logic                    al_done,
  input  logic [IDX_W-1:0]        al_tidx,
  input  logic                    rl_en,
  input  logic [$clog2(LB_N)-1:0] rl_slot,
  input  logic                    st_en,
  input  logic [AGE_W-1:0]        st_age,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic                    cm_en,
  input  logic [$clog2(LB_N)-1:0] cm_slot,
  output logic                    tw_en,
  output logic [IDX_W-1:0]        tw_idx,
  output logic                    tw_clr,
  output logic                    viol_valid,
  output logic [$clog2(LB_N)-1:0] viol_slot
);
  localparam int unsigned SLOT_W = $clog2(LB_N);
  localparam int unsigned LINE_W = ADDR_W - LINE_LSB;

  lb_flags_t          flags_q [LB_N];
  lb_flags_t          flags_d [LB_N];
  logic [AGE_W-1:0]   age_q   [LB_N];
  logic [LINE_W-1:0]  line_q  [LB_N];
  logic [IDX_W-1:0]   tidx_q  [LB_N];
  logic [LB_N-1:0]    match;
  logic               any_d;
  logic [SLOT_W-1:0]  first_d;
  logic               viol_q;
  logic [SLOT_W-1:0]  vslot_q;

  // store comparator per entry
  for (genvar i = 0; i < LB_N; i++) begin : g_cmp
    logic [AGE_W-1:0] diff;
    logic             younger;
    assign diff    = age_q[i] - st_age;
    assign younger = (diff != '0) && !diff[AGE_W-1];
    assign match[i] = st_en && flags_q[i].vld && flags_q[i].avld &&
                      flags_q[i].done && younger &&
                      (line_q[i] == st_addr[ADDR_W-1:LINE_LSB]);
  end

  // lowest flagged slot wins the report
  always_comb begin
    any_d   = |match;
    first_d = '0;
    for (int i = LB_N - 1; i >= 0; i--) begin
      if (match[i]) first_d = SLOT_W'(i);
    end
  end

  // commit reads the entry state before this cycle's updates
  assign tw_en  = cm_en && flags_q[cm_slot].vld && flags_q[cm_slot].upd;
  assign tw_clr = flags_q[cm_slot].hit;
  assign tw_idx = tidx_q[cm_slot];

  always_comb begin
    flags_d = flags_q;
    for (int i = 0; i < LB_N; i++) begin
      if (match[i]) flags_d[i].hit = 1'b1;
    end
    if (cm_en) flags_d[cm_slot].vld  = 1'b0;
    if (rl_en) flags_d[rl_slot].done = 1'b1;
    if (al_en) begin
      flags_d[al_slot].vld  = 1'b1;
      flags_d[al_slot].avld = al_avld;
      flags_d[al_slot].upd  = al_upd;
      flags_d[al_slot].done = al_done;
      flags_d[al_slot].hit  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '{default: '0};
      viol_q  <= 1'b0;
      vslot_q <= '0;
    end else begin
      flags_q <= flags_d;
      viol_q  <= any_d;
      if (any_d) vslot_q <= first_d;
    end
  end

  always_ff @(posedge clk) begin
    if (al_en) begin
      age_q[al_slot]  <= al_age;
      line_q[al_slot] <= al_addr[ADDR_W-1:LINE_LSB];
      tidx_q[al_slot] <= al_tidx;
    end
  end

  assign viol_valid = viol_q;
  assign viol_slot  = vslot_q;

  // R4
  viol_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $past(st_en));
  // R4
  viol_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> flags_q[viol_slot].hit);
  // R3
  issue_marks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (al_en && al_done) |=> flags_q[$past(al_slot)].done);
endmodule

// File: rtl/ld_dep_predictor.sv
module ld_dep_predictor
  import ldp_pkg::*;
#(
  parameter int unsigned IP_W      = IP_W_DEF,
  parameter int unsigned ADDR_W    = ADDR_W_DEF,
  parameter int unsigned TBL_IDX_W = TBL_IDX_DEF,
  parameter int unsigned CTR_W     = CTR_W_DEF,
  parameter int unsigned LB_N      = LB_N_DEF,
  parameter int unsigned AGE_W     = AGE_W_DEF,
  parameter int unsigned LINE_LSB  = LINE_LSB_DEF,
  localparam int unsigned SLOT_W   = $clog2(LB_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [SLOT_W-1:0] disp_slot,
  input  logic [IP_W-1:0]   disp_ip,
  input  logic [AGE_W-1:0]  disp_age,
  input  logic [ADDR_W-1:0] disp_addr,
  input  logic              disp_addr_vld,
  input  logic              disp_older_unk,
  output logic              disp_go,
  output logic              disp_issue,
  input  logic              rel_valid,
  input  logic [SLOT_W-1:0] rel_slot,
  input  logic              st_valid,
  input  logic [AGE_W-1:0]  st_age,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              cm_valid,
  input  logic [SLOT_W-1:0] cm_slot,
  output logic              viol_valid,
  output logic [SLOT_W-1:0] viol_slot
);
  logic [1:0]           rs_q;
  logic                 rst_i_n;
  logic [TBL_IDX_W-1:0] lk_idx;
  logic                 tw_en;
  logic [TBL_IDX_W-1:0] tw_idx;
  logic                 tw_clr;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign disp_issue = disp_valid && (!disp_older_unk || disp_go);

  ldp_hist_table #(
    .IP_W (IP_W),
    .IDX_W(TBL_IDX_W),
    .CTR_W(CTR_W)
  ) u_table (
    .clk   (clk),
    .rst_n (rst_i_n),
    .lk_ip (disp_ip),
    .lk_idx(lk_idx),
    .lk_go (disp_go),
    .wr_en (tw_en),
    .wr_idx(tw_idx),
    .wr_clr(tw_clr)
  );

  ldp_load_buf #(
    .LB_N    (LB_N),
    .AGE_W   (AGE_W),
    .ADDR_W  (ADDR_W),
    .IDX_W   (TBL_IDX_W),
    .LINE_LSB(LINE_LSB)
  ) u_lbuf (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .al_en     (disp_valid),
    .al_slot   (disp_slot),
    .al_age    (disp_age),
    .al_addr   (disp_addr),
    .al_avld   (disp_addr_vld),
    .al_upd    (disp_older_unk),
    .al_done   (disp_issue),
    .al_tidx   (lk_idx),
    .rl_en     (rel_valid),
    .rl_slot   (rel_slot),
    .st_en     (st_valid),
    .st_age    (st_age),
    .st_addr   (st_addr),
    .cm_en     (cm_valid),
    .cm_slot   (cm_slot),
    .tw_en     (tw_en),
    .tw_idx    (tw_idx),
    .tw_clr    (tw_clr),
    .viol_valid(viol_valid),
    .viol_slot (viol_slot)
  );
endmodule

// File: tb/ld_dep_predictor_tb.sv
module ld_dep_predictor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0;
  logic [2:0]  disp_slot = '0;
  logic [31:0] disp_ip = '0;
  logic [5:0]  disp_age = '0;
  logic [31:0] disp_addr = '0;
  logic        disp_addr_vld = 1'b0;
  logic        disp_older_unk = 1'b0;
  logic        disp_go;
  logic        disp_issue;
  logic        rel_valid = 1'b0;
  logic [2:0]  rel_slot = '0;
  logic        st_valid = 1'b0;
  logic [5:0]  st_age = '0;
  logic [31:0] st_addr = '0;
  logic        cm_valid = 1'b0;
  logic [2:0]  cm_slot = '0;
  logic        viol_valid;
  logic [2:0]  viol_slot;

  ld_dep_predictor u_dut (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string tag = "R2";
  int ages = 10;

  // behavioural reference state
  int          m_ctr [64];
  bit          m_vld [8];
  bit          m_avld[8];
  bit          m_upd [8];
  bit          m_done[8];
  bit          m_hit [8];
  int          m_age [8];
  logic [31:0] m_addr[8];
  int          m_idx [8];
  bit          e_vv = 0;
  int          e_vs = 0;

  function automatic int hidx(logic [31:0] ip);
    int r = 0;
    for (int b = 0; b < 32; b++) if (ip[b]) r = r ^ (1 << (b % 6));
    return r;
  endfunction

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cycle();
    bit eg;
    bit tv;
    int fs;
    #1;
    eg = (m_ctr[hidx(disp_ip)] == 15);
    chk(int'(disp_go), int'(eg), "disp_go");
    chk(int'(disp_issue), int'(disp_valid && (!disp_older_unk || eg)), "disp_issue");
    chk(int'(viol_valid), int'(e_vv), "viol_valid");
    if (e_vv) chk(int'(viol_slot), e_vs, "viol_slot");
    @(posedge clk);
    tv = 0; fs = 0;
    if (st_valid) begin
      for (int i = 7; i >= 0; i--) begin
        int d;
        d = (m_age[i] - int'(st_age)) & 63;
        if (m_vld[i] && m_avld[i] && m_done[i] && d != 0 && d < 32 &&
            (m_addr[i] >> 3) == (st_addr >> 3)) begin
          tv = 1; fs = i;
        end
      end
    end
    if (cm_valid && m_vld[cm_slot] && m_upd[cm_slot]) begin
      if (m_hit[cm_slot]) m_ctr[m_idx[cm_slot]] = 0;
      else if (m_ctr[m_idx[cm_slot]] < 15) m_ctr[m_idx[cm_slot]]++;
    end
    if (st_valid) begin
      for (int i = 0; i < 8; i++) begin
        int d;
        d = (m_age[i] - int'(st_age)) & 63;
        if (m_vld[i] && m_avld[i] && m_done[i] && d != 0 && d < 32 &&
            (m_addr[i] >> 3) == (st_addr >> 3)) m_hit[i] = 1;
      end
    end
    if (cm_valid) m_vld[cm_slot] = 0;
    if (rel_valid) m_done[rel_slot] = 1;
    if (disp_valid) begin
      m_vld[disp_slot]  = 1;
      m_avld[disp_slot] = disp_addr_vld;
      m_upd[disp_slot]  = disp_older_unk;
      m_done[disp_slot] = !disp_older_unk || eg;
      m_hit[disp_slot]  = 0;
      m_age[disp_slot]  = disp_age;
      m_addr[disp_slot] = disp_addr;
      m_idx[disp_slot]  = hidx(disp_ip);
    end
    e_vv = tv; e_vs = fs;
    @(negedge clk);
    disp_valid = 0; rel_valid = 0; st_valid = 0; cm_valid = 0;
  endtask

  task automatic dispatch(input int s, input logic [31:0] ip, input logic [31:0] a,
                          input bit unk, input bit av);
    disp_valid = 1; disp_slot = 3'(s); disp_ip = ip; disp_addr = a;
    disp_older_unk = unk; disp_addr_vld = av; disp_age = 6'(ages);
    cycle();
  endtask
  task automatic release_ld(input int s);
    rel_valid = 1; rel_slot = 3'(s); cycle();
  endtask
  task automatic store(input int age, input logic [31:0] a);
    st_valid = 1; st_age = 6'(age); st_addr = a; cycle();
  endtask
  task automatic commit(input int s);
    cm_valid = 1; cm_slot = 3'(s); cycle();
  endtask
  task automatic peek(input logic [31:0] ip);
    disp_ip = ip; cycle();
  endtask
  task automatic train(input logic [31:0] ip, input int n);
    for (int k = 0; k < n; k++) begin
      ages = (ages + 1) & 63;
      dispatch(0, ip, 32'h40, 1, 1);
      release_ld(0);
      commit(0);
    end
  endtask

  localparam logic [31:0] IP_A = 32'h0000_1234;
  localparam logic [31:0] IP_B = 32'h0000_1275; // folds like IP_A
  localparam logic [31:0] IP_C = 32'h0000_1235;
  localparam logic [31:0] IP_D = 32'h0000_0777;

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_ctr[i] = 0;
    for (int i = 0; i < 8; i++) begin
      m_vld[i] = 0; m_avld[i] = 0; m_upd[i] = 0; m_done[i] = 0; m_hit[i] = 0;
      m_age[i] = 0; m_addr[i] = '0; m_idx[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tag = "R2"; peek(IP_A); peek(IP_D);
    tag = "R3"; dispatch(7, IP_C, 32'h900, 0, 1); dispatch(6, IP_C, 32'h900, 1, 1);
    commit(7); commit(6);
    tag = "R5"; train(IP_A, 15);
    tag = "R1"; peek(IP_B); peek(IP_C); peek(IP_A);
    tag = "R5"; train(IP_D, 14);
    tag = "R7"; ages++; dispatch(0, IP_D, 32'h40, 0, 1); commit(0); peek(IP_D);
    tag = "R5"; train(IP_D, 2); peek(IP_D);
    tag = "R4"; ages = 20;
    dispatch(3, IP_A, 32'h300, 1, 1);
    dispatch(5, IP_A, 32'h305, 1, 1);
    store(25, 32'h300);
    store(18, 32'h308);
    tag = "R11"; ages = 21; dispatch(1, IP_A, 32'h400, 1, 0); store(19, 32'h400);
    tag = "R4"; store(18, 32'h301); peek(IP_A);
    tag = "R6"; commit(3); commit(5); commit(1); peek(IP_A);
    tag = "R10"; store(18, 32'h300);
    tag = "R9"; ages = 30; dispatch(2, IP_C, 32'h500, 1, 1);
    store(28, 32'h500); release_ld(2); store(29, 32'h507); commit(2); peek(IP_C);
    tag = "R8"; ages = 40; dispatch(4, IP_D, 32'h200, 1, 1); store(39, 32'h200);
    disp_valid = 1; disp_slot = 3'd6; disp_ip = IP_D; disp_addr = 32'h600;
    disp_older_unk = 1; disp_addr_vld = 1; disp_age = 6'd41;
    cm_valid = 1; cm_slot = 3'd4; cycle();
    peek(IP_D); commit(6); peek(IP_D);
    repeat (2) peek(IP_A);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule